// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block controls the power states of a small microcontroller core. Software asks for a state through write strobes for idle, stop and suspend. It can also set a configuration bit that turns the regulator off while in stop. A request does not act at once. It waits until the instruction that wrote it has completed, and the `instr_done` strobe marks that point. From the state it reaches, the sequencer drives gating signals for the CPU clock, the high-frequency oscillator, the peripheral clocks and the regulator.

The exits differ by state:
- **Idle** returns to run on any pending interrupt.
- **Stop** can be left only through a reset. When the regulator was configured off at entry, only the external pin or power-on reset can end it.
- **Suspend** ends on a pin pattern match, a low-speed timer overflow, or a comparator low output when the comparator wake is enabled. The oscillator restarts first. The CPU clock returns only after a fixed number of low-speed clock ticks. A one-cycle resume pulse then tells the core to continue at the next instruction, and a wake-interrupt pulse goes with it when that was enabled.
- **Any reset** (external pin, missing-clock timeout, power-on) returns the sequencer to run and pulses `core_rst`, so the core restarts from address zero.

Top module: `lpm_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1 and all of `cpu_clk_en`, `hfosc_en`, `periph_clk_en` and `reg_en` are 1. An accepted reset event (`ext_rst`, or `mcd_en & mcd_timeout`) returns the sequencer to run and makes `core_rst` 1 for exactly the following cycle.
- R2: A mode request strobe takes effect at the first clock edge where `instr_done` is 1, which may be the edge of the strobe itself. Before that edge the outputs stay at the run values.
- R3: When several requests are pending at entry, stop wins over suspend, and suspend wins over idle.
- R4: In stop, `cpu_clk_en`, `hfosc_en` and `periph_clk_en` are 0. Wake inputs and interrupts have no effect; only a reset ends stop.
- R5: If the regulator-off bit (`regoff_wr` with `regoff_val`=1) was set before the cycle that entered stop, `reg_en` is 0 during that stop. A missing-clock timeout is then ignored, and only `ext_rst` or `rst_n` ends stop.
- R6: In suspend, the CPU clock, oscillator and peripheral clock enables are 0 and `reg_en` is 1. `pmatch`, `tmr_ovf`, or `cmp_low` with `cmp_en`=1 starts the wake; `cmp_low` alone does not.
- R7: After a non-reset wake, `hfosc_en` is 1 and `cpu_clk_en` stays 0 until the edge carrying the 8th `ls_tick`. From that edge the run enables return, and `resume_pulse` is 1 for one cycle.
- R8: `wake_irq` is 1 in the same cycle as `resume_pulse` only if `wake_irq_en` was 1 on the wake edge.
- R9: A reset during suspend or its settle phase gives `core_rst` and no `resume_pulse`.
- R10: In idle only `cpu_clk_en` is 0. `irq_pend` returns the sequencer to run at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| set_idle | input | 1 | Idle request write strobe |
| set_stop | input | 1 | Stop request write strobe |
| set_susp | input | 1 | Suspend request write strobe |
| regoff_wr | input | 1 | Write strobe for the regulator-off-in-stop bit |
| regoff_val | input | 1 | Value written to the regulator-off bit |
| instr_done | input | 1 | Current instruction has completed |
| ext_rst | input | 1 | External reset pin request |
| mcd_en | input | 1 | Missing-clock detector enabled |
| mcd_timeout | input | 1 | Missing-clock detector timeout |
| pmatch | input | 1 | Pin pattern match wake |
| tmr_ovf | input | 1 | Low-speed timer overflow wake |
| cmp_low | input | 1 | Comparator output low |
| cmp_en | input | 1 | Comparator wake enable |
| irq_pend | input | 1 | Enabled interrupt pending (idle exit) |
| wake_irq_en | input | 1 | Wake source interrupt enabled |
| ls_tick | input | 1 | One-cycle tick of the low-speed clock |
| cpu_clk_en | output | 1 | CPU clock enable |
| hfosc_en | output | 1 | High-frequency oscillator enable |
| periph_clk_en | output | 1 | Digital peripheral clock enable |
| reg_en | output | 1 | Regulator enable |
| resume_pulse | output | 1 | Continue at next instruction, one cycle |
| wake_irq | output | 1 | Wake interrupt request, one cycle |
| core_rst | output | 1 | Core reset, program counter to zero |

## Verification
The gating enables are decoded from the state register, so they change on the clock edge that samples the causing input, one cycle after the stimulus is applied. `core_rst`, `resume_pulse` and `wake_irq` are registered pulses, high for exactly the cycle after that edge. The only exception is `core_rst` under `rst_n`, which asserts at once. Stimulus is applied on the falling edge and the outputs are compared on the next falling edge, so every result is read one full edge after its cause. The settle window is counted in ticks rather than cycles, and an idle cycle inside the window shows that cycles without a tick do not advance it.

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int SETTLE_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_idle,
  input  logic set_stop,
  input  logic set_susp,
  input  logic regoff_wr,
  input  logic regoff_val,
  input  logic instr_done,
  input  logic ext_rst,
  input  logic mcd_en,
  input  logic mcd_timeout,
  input  logic pmatch,
  input  logic tmr_ovf,
  input  logic cmp_low,
  input  logic cmp_en,
  input  logic irq_pend,
  input  logic wake_irq_en,
  input  logic ls_tick,
  output logic cpu_clk_en,
  output logic hfosc_en,
  output logic periph_clk_en,
  output logic reg_en,
  output logic resume_pulse,
  output logic wake_irq,
  output logic core_rst
);
  localparam int CW = $clog2(SETTLE_TICKS + 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_STOP, S_SUSP, S_SETTLE} st_t;

  st_t           st;
  logic [2:0]    req;
  logic          regoff_q, stop_regoff, irq_lat;
  logic [CW-1:0] cnt;

  wire       wake     = pmatch | tmr_ovf | (cmp_low & cmp_en);
  wire       rst_evt  = ext_rst | (mcd_en & mcd_timeout & !(st == S_STOP && stop_regoff));
  wire [2:0] req_all  = req | {set_stop, set_susp, set_idle};
  wire       last_tk  = ls_tick && (cnt == CW'(SETTLE_TICKS - 1));

  assign cpu_clk_en    = (st == S_RUN);
  assign hfosc_en      = (st == S_RUN) || (st == S_IDLE) || (st == S_SETTLE);
  assign periph_clk_en = (st == S_RUN) || (st == S_IDLE);
  assign reg_en        = !(st == S_STOP && stop_regoff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN; req <= '0; regoff_q <= 1'b0; stop_regoff <= 1'b0;
      irq_lat <= 1'b0; cnt <= '0;
      core_rst <= 1'b1; resume_pulse <= 1'b0; wake_irq <= 1'b0;
    end else begin
      core_rst     <= 1'b0;
      resume_pulse <= 1'b0;
      wake_irq     <= 1'b0;
      if (rst_evt) begin
        st <= S_RUN; req <= '0; regoff_q <= 1'b0; stop_regoff <= 1'b0;
        irq_lat <= 1'b0; cnt <= '0;
        core_rst <= 1'b1;
      end else begin
        if (regoff_wr) regoff_q <= regoff_val;
        case (st)
          S_RUN:
            if (instr_done && req_all != 3'b000) begin
              req <= '0;
              if (req_all[2]) begin
                st <= S_STOP;
                stop_regoff <= regoff_q;
              end else if (req_all[1]) st <= S_SUSP;
              else st <= S_IDLE;
            end else begin
              req <= req_all;
            end
          S_IDLE:
            if (irq_pend) st <= S_RUN;
          S_SUSP:
            if (wake) begin
              st <= S_SETTLE;
              cnt <= '0;
              irq_lat <= wake_irq_en;
            end
          S_SETTLE:
            if (last_tk) begin
              st <= S_RUN;
              cnt <= '0;
              resume_pulse <= 1'b1;
              wake_irq <= irq_lat;
              irq_lat <= 1'b0;
            end else if (ls_tick) begin
              cnt <= cnt + 1'b1;
            end
          S_STOP: ;
          default: st <= S_RUN;
        endcase
      end
    end
  end

  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !ext_rst && !mcd_timeout) |=> (st == S_STOP && !cpu_clk_en));

  assert_regoff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && stop_regoff && !ext_rst) |=> (st == S_STOP && !reg_en));

  assert_settle_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP && wake && !rst_evt) |=> (hfosc_en && !cpu_clk_en));

  assert_resume_after_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && !rst_evt ##1 st == S_RUN) |-> resume_pulse);

  assert_irq_with_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> resume_pulse);

  assert_reset_no_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_pulse, core_rst}));

  assert_idle_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && irq_pend && !rst_evt) |=> cpu_clk_en);
endmodule

// File: tb/tb_lpm_seq.sv
module tb_lpm_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] stim = '0;
  logic cpu_clk_en, hfosc_en, periph_clk_en, reg_en, resume_pulse, wake_irq, core_rst;
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpm_seq dut (
    .clk(clk), .rst_n(rst_n),
    .set_idle(stim[15]), .set_stop(stim[14]), .set_susp(stim[13]),
    .regoff_wr(stim[12]), .regoff_val(stim[11]), .instr_done(stim[10]),
    .ext_rst(stim[9]), .mcd_en(stim[8]), .mcd_timeout(stim[7]),
    .pmatch(stim[6]), .tmr_ovf(stim[5]), .cmp_low(stim[4]), .cmp_en(stim[3]),
    .irq_pend(stim[2]), .wake_irq_en(stim[1]), .ls_tick(stim[0]),
    .cpu_clk_en(cpu_clk_en), .hfosc_en(hfosc_en), .periph_clk_en(periph_clk_en),
    .reg_en(reg_en), .resume_pulse(resume_pulse), .wake_irq(wake_irq), .core_rst(core_rst)
  );

  localparam logic [15:0] I_IDLE = 16'h8000, I_STOP = 16'h4000, I_SUSP = 16'h2000,
    I_ROW = 16'h1000, I_ROV = 16'h0800, I_DONE = 16'h0400, I_EXT = 16'h0200,
    I_MCDE = 16'h0100, I_MCDT = 16'h0080, I_PM = 16'h0040, I_TOVF = 16'h0020,
    I_CMPL = 16'h0010, I_CMPE = 16'h0008, I_IRQ = 16'h0004, I_WIE = 16'h0002,
    I_TICK = 16'h0001;
  localparam logic [6:0] E_RUN = 7'b1111000, E_IDLE = 7'b0111000, E_STOP = 7'b0001000,
    E_STOPOFF = 7'b0000000, E_SUSP = 7'b0001000, E_SETL = 7'b0101000,
    E_RES = 7'b1111100, E_RESI = 7'b1111110, E_RST = 7'b1111001;

  localparam int N = 47;
  localparam logic [22:0] VEC [N] = '{
    {16'h0000, E_RUN},                        // R1 plain run
    {I_IDLE, E_RUN},                          // R2 deferred until instr_done
    {I_DONE, E_IDLE},                         // R2 R10
    {16'h0000, E_IDLE},                       // R10
    {I_IRQ, E_RUN},                           // R10 exit on interrupt
    {I_SUSP | I_DONE, E_SUSP},                // R2 R6 same-edge entry
    {I_CMPL, E_SUSP},                         // R6 comparator not enabled
    {I_PM | I_WIE, E_SETL},                   // R6 R7 port match
    {I_TICK, E_SETL}, {I_TICK, E_SETL}, {I_TICK, E_SETL}, {I_TICK, E_SETL},
    {I_TICK, E_SETL}, {I_TICK, E_SETL}, {I_TICK, E_SETL},   // R7 ticks 1..7
    {16'h0000, E_SETL},                       // R7 no tick, no progress
    {I_TICK, E_RESI},                         // R7 R8 8th tick
    {16'h0000, E_RUN},                        // R7 single-cycle pulse
    {I_SUSP | I_DONE, E_SUSP},                // R6
    {I_TOVF, E_SETL},                         // R6 timer wake, no irq
    {I_TICK, E_SETL}, {I_TICK, E_SETL}, {I_TICK, E_SETL}, {I_TICK, E_SETL},
    {I_TICK, E_SETL}, {I_TICK, E_SETL}, {I_TICK, E_SETL},
    {I_TICK, E_RES},                          // R8 no wake_irq
    {I_SUSP | I_DONE, E_SUSP},                // R6
    {I_CMPL | I_CMPE, E_SETL},                // R6 comparator wake
    {I_EXT, E_RST},                           // R9 reset during settle
    {16'h0000, E_RUN},                        // R1
    {I_STOP | I_SUSP | I_IDLE | I_DONE, E_STOP}, // R3 stop priority
    {I_PM | I_TOVF | I_IRQ, E_STOP},          // R4 wakes ignored
    {I_MCDE | I_MCDT, E_RST},                 // R4 R1 missing-clock reset
    {16'h0000, E_RUN},                        // R1
    {I_ROW | I_ROV, E_RUN},                   // R5 config write
    {I_STOP | I_DONE, E_STOPOFF},             // R5 regulator off
    {I_MCDE | I_MCDT, E_STOPOFF},             // R5 mcd ignored
    {I_PM, E_STOPOFF},                        // R5 R4
    {I_EXT, E_RST},                           // R5 pin reset exits
    {16'h0000, E_RUN},                        // R1
    {I_SUSP | I_DONE, E_SUSP},                // R6
    {I_EXT, E_RST},                           // R9 reset in suspend
    {16'h0000, E_RUN},                        // R9
    {I_IDLE | I_DONE, E_IDLE},                // R10
    {I_EXT, E_RST}                            // R1 reset from idle
  };

  function automatic logic [6:0] outs();
    return {cpu_clk_en, hfosc_en, periph_clk_en, reg_en, resume_pulse, wake_irq, core_rst};
  endfunction

  task automatic check(input logic [6:0] exp, input string req);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, outs(), exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2);
    check(E_RST, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      stim = VEC[i][22:7];
      @(negedge clk);
      check(VEC[i][6:0], $sformatf("R1-table row %0d", i));
    end
    stim = I_ROW | I_ROV;
    @(negedge clk);
    stim = I_STOP | I_DONE;
    @(negedge clk);
    stim = '0;
    check(E_STOPOFF, "R5 regulator-off stop");
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #1;
    check(E_RST, "R1 R5 power-on reset ends stop");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(E_RUN, "R1 run after power-on");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule